// File: doc/BRIEF.md
# Short Conditional Branch Unit

This unit resolves the short relative branches of a 16-bit processor with segmented addressing. A sequencer hands it one opcode byte together with the signed 8-bit displacement that followed that byte. It also supplies the current instruction pointer, the code segment, five status flags (overflow, carry, zero, sign, parity) and the count register. The instruction pointer has already been advanced past the displacement byte when it reaches the unit.

On a one-cycle `start` pulse the unit sorts the opcode into one of four groups: a flag-conditioned jump, a jump taken when the count register is zero, a decrementing loop branch, or an illegal opcode. It then evaluates the condition and forms the branch target by sign-extending the displacement and adding it to the instruction pointer. One cycle later it presents the resolved next instruction pointer, the unchanged code segment and the count register value to write back, with a one-cycle `done` strobe. For loop opcodes it also raises a count write-enable.

Top module: `short_branch_unit`

## Requirements
- R1: An opcode whose upper nibble is not 0x7 and that is not one of 0xE0, 0xE1, 0xE2 or 0xE3 sets `illegal`=1, `taken`=0, `ip_out`=`ip_in` and `cx_we`=0. Every legal opcode sets `illegal`=0.
- R2: A cycle with `start`=1 yields `done`=1 in the following cycle. A cycle with `start`=0 yields `done`=0 in the following cycle. While `start` stays 0, every result output holds its value.
- R3: The branch target is `ip_in` plus the displacement sign-extended from bit 7, taken modulo 2^16.
- R4: Single-flag jumps use the opcode pairs 0x70/0x71 on OF, 0x72/0x73 on CF, 0x74/0x75 on ZF, 0x78/0x79 on SF and 0x7A/0x7B on PF. The even opcode is taken when its flag is 1 and the odd opcode when its flag is 0.
- R5: 0x76 is taken when CF=1 or ZF=1. 0x77 is taken when CF=0 and ZF=0.
- R6: 0x7C is taken when SF differs from OF. 0x7D is taken when SF equals OF.
- R7: 0x7E is taken when SF differs from OF or ZF=1. 0x7F is taken when SF equals OF and ZF=0.
- R8: 0xE3 is taken exactly when `cx_in` is 0x0000, and it does not request a count write-back.
- R9: For 0xE0, 0xE1 and 0xE2, `cx_out` is `cx_in` minus one modulo 2^16 (0x0000 becomes 0xFFFF) and `cx_we`=1, whether or not the branch is taken.
- R10: Loop conditions use the decremented count N. 0xE2 is taken when N is nonzero. 0xE1 is taken when ZF=1 and N is nonzero. 0xE0 is taken when ZF=0 and N is nonzero.
- R11: A taken branch gives `ip_out` equal to the target. A branch that is not taken gives `ip_out`=`ip_in`. `cs_out` always equals `cs_in`.
- R12: For every opcode other than 0xE0 to 0xE2, `cx_we`=0 and `cx_out`=`cx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the operands presented this cycle |
| opcode | input | 8 | Branch opcode byte |
| disp | input | 8 | Signed displacement byte |
| ip_in | input | 16 | Instruction pointer past the displacement |
| cs_in | input | 16 | Current code segment |
| cx_in | input | 16 | Current count register |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| done | output | 1 | One-cycle result strobe |
| taken | output | 1 | Branch was taken |
| illegal | output | 1 | Opcode not handled by this unit |
| ip_out | output | 16 | Next instruction pointer |
| cs_out | output | 16 | Code segment after the branch |
| cx_out | output | 16 | Count register value to write back |
| cx_we | output | 1 | Count register write-back enable |

## Verification
The hardest cases sit at the edges of the loop count. With a count of 0x0000 the decrement wraps to 0xFFFF, and the loop branch must be taken. With a count of 0x0001 the new count reaches zero, so the loop branch must fall through, yet the write-back must still happen. The stimulus drives these counts directly and pairs each with both zero-flag values. It also places the instruction pointer near 0xFFFF and 0x0000 with displacements 0x7F, 0x80 and 0xFF, so the target addition wraps in both directions. Every flag-conditioned opcode is swept over all 32 flag combinations.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int OPC_W = 8;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic zro;
        logic sgn;
        logic par;
    } sbr_flags_t;

    typedef enum logic [1:0] {
        GRP_FLAGJMP = 2'd0,
        GRP_CXZERO  = 2'd1,
        GRP_LOOP    = 2'd2,
        GRP_BAD     = 2'd3
    } sbr_group_t;

    localparam logic [3:0]       FLAGJMP_HI = 4'h7;
    localparam logic [OPC_W-1:0] OPC_CXZERO = 8'hE3;
    localparam logic [OPC_W-3:0] LOOP_HI    = 6'b111000;

    function automatic sbr_group_t sbr_classify(input logic [OPC_W-1:0] op);
        sbr_group_t g;
        if (op[7:4] == FLAGJMP_HI)
            g = GRP_FLAGJMP;
        else if (op == OPC_CXZERO)
            g = GRP_CXZERO;
        else if (op[7:2] == LOOP_HI && op[1:0] != 2'b11)
            g = GRP_LOOP;
        else
            g = GRP_BAD;
        return g;
    endfunction

endpackage

// File: rtl/sbr_cond_eval.sv
module sbr_cond_eval
    import sbr_pkg::*;
(
    input  logic [3:0]  sel,
    input  sbr_flags_t  flg,
    output logic        hit
);
    // Bits [3:1] pick the base condition; bit 0 inverts it.
    logic base;

    always_comb begin
        unique case (sel[3:1])
            3'd0: base = flg.ovf;
            3'd1: base = flg.cry;
            3'd2: base = flg.zro;
            3'd3: base = flg.zro | flg.cry;
            3'd4: base = flg.sgn;
            3'd5: base = flg.par;
            3'd6: base = flg.sgn ^ flg.ovf;
            default: base = (flg.sgn ^ flg.ovf) | flg.zro;
        endcase
        hit = base ^ sel[0];
    end
endmodule

// File: rtl/sbr_count_eval.sv
module sbr_count_eval #(
    parameter int CX_W = 16
) (
    input  logic [CX_W-1:0] cx_in,
    input  logic [1:0]      kind,
    input  logic            zf,
    output logic [CX_W-1:0] cx_dec,
    output logic            loop_hit,
    output logic            cx_is_zero
);
    logic dec_nonzero;

    always_comb begin
        cx_dec      = cx_in - CX_W'(1);
        dec_nonzero = |cx_dec;
        cx_is_zero  = ~|cx_in;
        unique case (kind)
            2'b10:   loop_hit = dec_nonzero;
            2'b01:   loop_hit = zf & dec_nonzero;
            2'b00:   loop_hit = ~zf & dec_nonzero;
            default: loop_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbr_target.sv
module sbr_target #(
    parameter int IP_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [IP_W-1:0]   ip_in,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   target
);
    localparam int EXT_W = IP_W - DISP_W;

    logic [IP_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[IP_W-1:0];
        end
    endgenerate

    assign target = ip_in + disp_ext;
endmodule

// File: rtl/short_branch_unit.sv
module short_branch_unit
    import sbr_pkg::*;
#(
    parameter int IP_W   = 16,
    parameter int SEG_W  = 16,
    parameter int CX_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [DISP_W-1:0]  disp,
    input  logic [IP_W-1:0]    ip_in,
    input  logic [SEG_W-1:0]   cs_in,
    input  logic [CX_W-1:0]    cx_in,
    input  logic               flag_of,
    input  logic               flag_cf,
    input  logic               flag_zf,
    input  logic               flag_sf,
    input  logic               flag_pf,
    output logic               done,
    output logic               taken,
    output logic               illegal,
    output logic [IP_W-1:0]    ip_out,
    output logic [SEG_W-1:0]   cs_out,
    output logic [CX_W-1:0]    cx_out,
    output logic               cx_we
);
    sbr_flags_t      flg;
    sbr_group_t      grp;
    logic            flag_hit, loop_hit, cx_zero, hit;
    logic [CX_W-1:0] cx_dec;
    logic [IP_W-1:0] target;

    assign flg = '{ovf: flag_of, cry: flag_cf, zro: flag_zf, sgn: flag_sf, par: flag_pf};
    assign grp = sbr_classify(opcode);

    sbr_cond_eval u_cond (
        .sel (opcode[3:0]),
        .flg (flg),
        .hit (flag_hit)
    );

    sbr_count_eval #(.CX_W(CX_W)) u_count (
        .cx_in      (cx_in),
        .kind       (opcode[1:0]),
        .zf         (flag_zf),
        .cx_dec     (cx_dec),
        .loop_hit   (loop_hit),
        .cx_is_zero (cx_zero)
    );

    sbr_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
        .ip_in  (ip_in),
        .disp   (disp),
        .target (target)
    );

    always_comb begin
        unique case (grp)
            GRP_FLAGJMP: hit = flag_hit;
            GRP_CXZERO:  hit = cx_zero;
            GRP_LOOP:    hit = loop_hit;
            default:     hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            taken   <= 1'b0;
            illegal <= 1'b0;
            ip_out  <= '0;
            cs_out  <= '0;
            cx_out  <= '0;
            cx_we   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                taken   <= hit;
                illegal <= (grp == GRP_BAD);
                ip_out  <= hit ? target : ip_in;
                cs_out  <= cs_in;
                cx_out  <= (grp == GRP_LOOP) ? cx_dec : cx_in;
                cx_we   <= (grp == GRP_LOOP);
            end
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done);                                                    // R2
    AST_DONE_ONLY_ON_START: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);                                                  // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(ip_out) && $stable(cx_out) && $stable(taken)));  // R2
    AST_SEGMENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        start |=> (cs_out == $past(cs_in)));                                // R11
    AST_FALLTHROUGH_IP: assert property (@(posedge clk) disable iff (rst)
        start |=> (taken || ip_out == $past(ip_in)));                       // R11
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> (!taken && !cx_we));                          // R1
    AST_NO_COUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (start && opcode[7:4] == 4'h7) |=> (!cx_we && cx_out == $past(cx_in))); // R12
    AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (start && opcode[7:2] == 6'b111000 && opcode[1:0] != 2'b11)
        |=> (cx_we && cx_out == CX_W'($past(cx_in) - CX_W'(1))));            // R9
endmodule

// File: tb/short_branch_unit_test.sv
module short_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  opcode, disp;
    logic [15:0] ip_in, cs_in, cx_in;
    logic        f_of, f_cf, f_zf, f_sf, f_pf;
    logic        done, taken, illegal, cx_we;
    logic [15:0] ip_out, cs_out, cx_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    short_branch_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .disp(disp),
        .ip_in(ip_in), .cs_in(cs_in), .cx_in(cx_in),
        .flag_of(f_of), .flag_cf(f_cf), .flag_zf(f_zf), .flag_sf(f_sf), .flag_pf(f_pf),
        .done(done), .taken(taken), .illegal(illegal), .ip_out(ip_out),
        .cs_out(cs_out), .cx_out(cx_out), .cx_we(cx_we)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // flags packed as {of, cf, zf, sf, pf}
    function automatic logic model_hit(input logic [7:0] op, input logic [4:0] f,
                                       input logic [15:0] cx);
        logic o, c, z, s, p;
        logic [15:0] n;
        {o, c, z, s, p} = f;
        n = cx - 16'd1;
        case (op)
            8'h70: return o;          8'h71: return !o;
            8'h72: return c;          8'h73: return !c;
            8'h74: return z;          8'h75: return !z;
            8'h76: return c || z;     8'h77: return !c && !z;
            8'h78: return s;          8'h79: return !s;
            8'h7A: return p;          8'h7B: return !p;
            8'h7C: return s != o;     8'h7D: return s == o;
            8'h7E: return (s != o) || z;
            8'h7F: return (s == o) && !z;
            8'hE3: return cx == 16'h0000;
            8'hE2: return n != 0;
            8'hE1: return z && (n != 0);
            8'hE0: return !z && (n != 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] op);
        if (op == 8'h76 || op == 8'h77) return "R5";
        if (op == 8'h7C || op == 8'h7D) return "R6";
        if (op == 8'h7E || op == 8'h7F) return "R7";
        if (op[7:4] == 4'h7)            return "R4";
        if (op == 8'hE3)                return "R8";
        if (op >= 8'hE0 && op <= 8'hE2) return "R10";
        return "R1";
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [7:0] d, input logic [15:0] ip,
                          input logic [15:0] cs, input logic [15:0] cx, input logic [4:0] f);
        logic legal, is_loop, h;
        logic [15:0] tgt, exp_ip;
        string rq;
        @(negedge clk);
        start = 1'b1; opcode = op; disp = d; ip_in = ip; cs_in = cs; cx_in = cx;
        {f_of, f_cf, f_zf, f_sf, f_pf} = f;
        @(negedge clk);
        start = 1'b0;
        is_loop = (op >= 8'hE0 && op <= 8'hE2);
        legal   = (op[7:4] == 4'h7) || is_loop || op == 8'hE3;
        h       = model_hit(op, f, cx);
        tgt     = ip + {{8{d[7]}}, d};            // R3
        exp_ip  = h ? tgt : ip;
        rq      = req_of(op);
        chk(done == 1'b1, "R2", "done", 16'(done), 16'd1);
        chk(illegal == !legal, "R1", "illegal", 16'(illegal), 16'(!legal));
        chk(taken == h, rq, "taken", 16'(taken), 16'(h));
        chk(ip_out == exp_ip, "R11", "ip_out", ip_out, exp_ip);
        chk(cs_out == cs, "R11", "cs_out", cs_out, cs);
        if (is_loop) begin
            chk(cx_we == 1'b1, "R9", "cx_we", 16'(cx_we), 16'd1);
            chk(cx_out == 16'(cx - 16'd1), "R9", "cx_out", cx_out, 16'(cx - 16'd1));
        end else begin
            chk(cx_we == 1'b0, "R12", "cx_we", 16'(cx_we), 16'd0);
            chk(cx_out == cx, "R12", "cx_out", cx_out, cx);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; opcode = '0; disp = '0;
        ip_in = '0; cs_in = '0; cx_in = '0;
        {f_of, f_cf, f_zf, f_sf, f_pf} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(done == 0, "R2", "reset done", 16'(done), 16'd0);
        chk(taken == 0, "R2", "reset taken", 16'(taken), 16'd0);
        chk(cx_we == 0, "R12", "reset cx_we", 16'(cx_we), 16'd0);
    endtask

    task automatic t_flag_sweep();   // R4 R5 R6 R7
        for (int op = 8'h70; op <= 8'h7F; op++)
            for (int f = 0; f < 32; f++)
                run_op(8'(op), 8'h10, 16'h1234, 16'hA000, 16'h0042, 5'(f));
    endtask

    task automatic t_displacement(); // R3: sign extension and modulo wrap
        run_op(8'h74, 8'h7F, 16'h1000, 16'h0100, 16'h0, 5'b00100);
        run_op(8'h74, 8'h80, 16'h1000, 16'h0100, 16'h0, 5'b00100);
        run_op(8'h74, 8'hFF, 16'h0000, 16'h0100, 16'h0, 5'b00100);
        run_op(8'h74, 8'h7F, 16'hFFF0, 16'h0100, 16'h0, 5'b00100);
        run_op(8'h74, 8'h00, 16'h5555, 16'h0100, 16'h0, 5'b00100);
        run_op(8'h75, 8'h80, 16'h0005, 16'h0100, 16'h0, 5'b00100);
    endtask

    task automatic t_cx_zero_jump(); // R8
        run_op(8'hE3, 8'hF0, 16'h2000, 16'h0200, 16'h0000, 5'b00000);
        run_op(8'hE3, 8'hF0, 16'h2000, 16'h0200, 16'h0001, 5'b11111);
        run_op(8'hE3, 8'h20, 16'h2000, 16'h0200, 16'hFFFF, 5'b00000);
    endtask

    task automatic t_loops();        // R9 R10: count edges with both ZF values
        logic [15:0] counts [4] = '{16'h0000, 16'h0001, 16'h0002, 16'h8000};
        for (int k = 0; k < 4; k++)
            for (int z = 0; z < 2; z++)
                for (int op = 8'hE0; op <= 8'hE2; op++)
                    run_op(8'(op), 8'hFC, 16'h0300, 16'h0F00, counts[k],
                           {2'b11, 1'(z), 2'b11});
    endtask

    task automatic t_illegal();      // R1
        logic [7:0] bad [7] = '{8'h00, 8'h6F, 8'h80, 8'hDF, 8'hE4, 8'hEB, 8'hFF};
        for (int i = 0; i < 7; i++)
            run_op(bad[i], 8'h40, 16'h4444, 16'h0700, 16'h0000, 5'b11111);
    endtask

    task automatic t_hold();         // R2: outputs hold and done drops without start
        logic [15:0] ip_q, cx_q;
        logic tk_q;
        run_op(8'hE2, 8'h10, 16'h0800, 16'h0100, 16'h0009, 5'b00000);
        ip_q = ip_out; cx_q = cx_out; tk_q = taken;
        opcode = 8'h70; ip_in = 16'hBEEF; cx_in = 16'h1111; f_of = 1'b0;
        @(negedge clk);
        chk(done == 0, "R2", "done after idle", 16'(done), 16'd0);
        chk(ip_out == ip_q, "R2", "ip_out hold", ip_out, ip_q);
        chk(cx_out == cx_q, "R2", "cx_out hold", cx_out, cx_q);
        chk(taken == tk_q, "R2", "taken hold", 16'(taken), 16'(tk_q));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_flag_sweep();
        t_displacement();
        t_cx_zero_jump();
        t_loops();
        t_illegal();
        t_hold();
        summary();
        $finish;
    end
endmodule